// File: doc/BRIEF.md
# Line-Clocked Byte Serializer with Free and Error Flags

This block lets a host in its own clock domain hand bytes to a serial line whose bit clock comes from the line device. The host writes a byte into a one-entry holding register. The line side copies that register into a shift register at each byte boundary and drives the bits out as NRZ, one bit per line-clock cycle. Because there is a holding register as well as a shifter, the host can supply the next byte while the current one is still going out.

A level output, `tx_free`, tells the host when the holding register may take another byte. Two sticky error flags support hosts that pace their writes by time instead of polling. One flags a write that arrives while the holding register is still occupied. The other flags a break in the stream, where the line had to insert a fill byte straight after a data byte. Both flags stay set until the host clears them. The load request and its acknowledge cross between the clock domains as toggles, each through a chain of two flip-flops. The underrun event crosses the same way.

Top module: `linetx_serializer`

## Requirements
- R1: After both resets, `tx_free` is 1, `overrun_err` and `underrun_err` are 0, and `line_dout` is 1.
- R2: A host-clock cycle with `wr_en`=1 while `tx_free`=1 captures `wr_data`, and `tx_free` reads 0 in the next host cycle.
- R3: Each byte goes out MSB first, one bit per line-clock cycle. `line_dout` changes only on the falling edge of `line_clk`, so it is stable at the rising edge. Frames are 8 bits long and the first frame starts at the first falling edge after line reset.
- R4: A host that waits for `tx_free` before each write gets its bytes sent in consecutive frames, with no fill frame between them.
- R5: Once the byte has moved into the shifter, `tx_free` returns to 1 without any host action.
- R6: A write while `tx_free`=0 leaves the byte that is already held unchanged and sets `overrun_err` in the next host cycle.
- R7: At a byte boundary with no byte held, the line sends an all-ones frame (8'hFF). `underrun_err` is set only when that fill frame directly follows a data frame. Idle fill after reset, or repeated fill frames, do not set it.
- R8: Both error flags are sticky. `err_clr`=1 clears them in the next host cycle. When a set event and `err_clr` occur in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host clock |
| host_rst_n | input | 1 | Host-domain reset, active low, asynchronous |
| wr_en | input | 1 | Byte write strobe, one host cycle |
| wr_data | input | 8 | Byte to send |
| err_clr | input | 1 | Clears both sticky error flags |
| tx_free | output | 1 | Holding register can accept a byte |
| overrun_err | output | 1 | Sticky: a write arrived while not free |
| underrun_err | output | 1 | Sticky: a fill frame followed a data frame |
| line_clk | input | 1 | Bit clock supplied by the line device |
| line_rst_n | input | 1 | Line-domain reset, active low, asynchronous |
| line_dout | output | 1 | NRZ serial data, MSB first |

## Verification
The drop of `tx_free` after a write, and a rise of `overrun_err`, are due one host cycle after the write edge. The bench reads them at the next falling host edge.

A written byte reaches the line only at a frame boundary that comes after at least two falling line edges of synchronisation. The return of `tx_free` and a rise of `underrun_err` follow that boundary by two to three host cycles. Checks on these results therefore wait out whole frames before reading the flags.

Serial data is logged at every rising line edge counted from line reset, so frame k occupies log bits 8k to 8k+7. The expected byte order is compared frame by frame.

// File: rtl/lintx_pkg.sv
package lintx_pkg;
    localparam int unsigned LTX_BYTE_W = 8;

    typedef enum logic {
        SRC_FILL = 1'b0,
        SRC_DATA = 1'b1
    } frame_src_e;
endpackage

// File: rtl/ltx_tog_sync.sv
module ltx_tog_sync #(
    parameter int unsigned STAGES    = 2,
    parameter bit          FALL_EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_i,
    output logic tog_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb chain_d = {chain_q[STAGES-2:0], tog_i};

    generate
        if (FALL_EDGE) begin : g_fall
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= chain_d;
            end
        end else begin : g_rise
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= chain_d;
            end
        end
    endgenerate

    assign tog_o = chain_q[STAGES-1];
endmodule

// File: rtl/ltx_host.sv
module ltx_host #(
    parameter int unsigned W           = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         err_clr,
    input  logic         ack_tog,
    input  logic         urun_tog,
    output logic [W-1:0] buf_o,
    output logic         req_tog_o,
    output logic         free_o,
    output logic         ovr_o,
    output logic         urun_o
);
    typedef struct packed {
        logic [W-1:0] data;
        logic         req;
        logic         ovr;
        logic         urun;
        logic         urun_seen;
    } host_st_t;

    host_st_t d, q;
    logic ack_s, urun_s;

    ltx_tog_sync #(.STAGES(SYNC_STAGES), .FALL_EDGE(1'b0)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .tog_i(ack_tog), .tog_o(ack_s)
    );
    ltx_tog_sync #(.STAGES(SYNC_STAGES), .FALL_EDGE(1'b0)) u_urun_sync (
        .clk(clk), .rst_n(rst_n), .tog_i(urun_tog), .tog_o(urun_s)
    );

    assign free_o = (q.req == ack_s);

    always_comb begin
        d = q;
        if (wr_en && free_o) begin
            d.data = wr_data;
            d.req  = ~q.req;
        end
        if (wr_en && !free_o) d.ovr = 1'b1;
        else if (err_clr)     d.ovr = 1'b0;
        d.urun_seen = urun_s;
        if (urun_s != q.urun_seen) d.urun = 1'b1;
        else if (err_clr)          d.urun = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign buf_o     = q.data;
    assign req_tog_o = q.req;
    assign ovr_o     = q.ovr;
    assign urun_o    = q.urun;

    // R2
    free_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && free_o) |=> !free_o);
    // R6
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !free_o) |=> ovr_o);
    // R6
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !free_o |=> $stable(buf_o));
    // R8
    urun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (urun_o && !err_clr) |=> urun_o);
endmodule

// File: rtl/ltx_line.sv
module ltx_line
    import lintx_pkg::*;
#(
    parameter int unsigned W           = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_tog,
    input  logic [W-1:0] buf_i,
    output logic         dout,
    output logic         ack_tog_o,
    output logic         urun_tog_o
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  shift;
        logic [CW-1:0] cnt;
        logic          ack;
        logic          urun;
        frame_src_e    src;
    } line_st_t;

    line_st_t d, q;
    logic req_s, pending, boundary;

    ltx_tog_sync #(.STAGES(SYNC_STAGES), .FALL_EDGE(1'b1)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .tog_i(req_tog), .tog_o(req_s)
    );

    assign pending  = (req_s != q.ack);
    assign boundary = (q.cnt == LAST);

    always_comb begin
        d = q;
        if (boundary) begin
            d.cnt = '0;
            if (pending) begin
                d.shift = buf_i;
                d.ack   = ~q.ack;
                d.src   = SRC_DATA;
            end else begin
                d.shift = '1;
                d.src   = SRC_FILL;
                if (q.src == SRC_DATA) d.urun = ~q.urun;
            end
        end else begin
            d.cnt   = q.cnt + 1'b1;
            d.shift = {q.shift[W-2:0], 1'b1};
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.shift <= '1;
            q.cnt   <= LAST;
            q.src   <= SRC_FILL;
        end else begin
            q <= d;
        end
    end

    assign dout       = q.shift[W-1];
    assign ack_tog_o  = q.ack;
    assign urun_tog_o = q.urun;

    // R7
    fill_ones_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (boundary && !pending) |=> dout);
    // R7
    no_reflag_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (boundary && !pending && q.src == SRC_FILL) |=> $stable(urun_tog_o));
    // R3
    mid_frame_chk: assert property (@(negedge clk) disable iff (!rst_n)
        !boundary |=> $stable(ack_tog_o));
endmodule

// File: rtl/linetx_serializer.sv
module linetx_serializer #(
    parameter int unsigned BYTE_W      = lintx_pkg::LTX_BYTE_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              host_clk,
    input  logic              host_rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              err_clr,
    output logic              tx_free,
    output logic              overrun_err,
    output logic              underrun_err,
    input  logic              line_clk,
    input  logic              line_rst_n,
    output logic              line_dout
);
    logic [BYTE_W-1:0] hold_byte;
    logic req_tog, ack_tog, urun_tog;

    ltx_host #(.W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_host (
        .clk(host_clk), .rst_n(host_rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .err_clr(err_clr),
        .ack_tog(ack_tog), .urun_tog(urun_tog),
        .buf_o(hold_byte), .req_tog_o(req_tog),
        .free_o(tx_free), .ovr_o(overrun_err), .urun_o(underrun_err)
    );

    ltx_line #(.W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk(line_clk), .rst_n(line_rst_n),
        .req_tog(req_tog), .buf_i(hold_byte),
        .dout(line_dout), .ack_tog_o(ack_tog), .urun_tog_o(urun_tog)
    );
endmodule

// File: tb/linetx_serializer_test.sv
module linetx_serializer_test;
    logic host_clk = 1'b0, line_clk = 1'b0;
    logic host_rst_n = 1'b0, line_rst_n = 1'b0;
    logic wr_en = 1'b0, err_clr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic tx_free, overrun_err, underrun_err, line_dout;

    int checks = 0, failures = 0;
    logic line_log [0:4095];
    int log_n = 0;

    localparam int NVEC = 6;
    localparam logic [7:0] VEC [NVEC] = '{8'hA5, 8'h01, 8'h80, 8'hFF, 8'h00, 8'h3C};

    always #2  host_clk = ~host_clk;
    always #20 line_clk = ~line_clk;

    linetx_serializer uut (
        .host_clk(host_clk), .host_rst_n(host_rst_n), .wr_en(wr_en),
        .wr_data(wr_data), .err_clr(err_clr), .tx_free(tx_free),
        .overrun_err(overrun_err), .underrun_err(underrun_err),
        .line_clk(line_clk), .line_rst_n(line_rst_n), .line_dout(line_dout)
    );

    always @(posedge line_clk) begin
        if (line_rst_n && log_n < 4096) begin
            line_log[log_n] = line_dout;
            log_n = log_n + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] frame_at(input int f);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[7-i] = line_log[8*f + i];
        return b;
    endfunction

    function automatic int first_data(input int from);
        for (int f = from; f < 500; f++)
            if (8*f + 8 <= log_n && frame_at(f) != 8'hFF) return f;
        return -1;
    endfunction

    task automatic hwrite(input logic [7:0] b, input logic clr);
        wr_en = 1'b1; wr_data = b; err_clr = clr;
        @(negedge host_clk);
        wr_en = 1'b0; err_clr = 1'b0;
    endtask

    task automatic hclear();
        err_clr = 1'b1;
        @(negedge host_clk);
        err_clr = 1'b0;
    endtask

    task automatic wait_free();
        for (int n = 0; n < 2000 && !tx_free; n++) @(negedge host_clk);
    endtask

    task automatic wait_line(input int n);
        repeat (n) @(posedge line_clk);
        @(negedge host_clk);
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int f0, fs;
        repeat (3) @(posedge line_clk);
        #1 line_rst_n = 1'b1;
        @(negedge host_clk);
        host_rst_n = 1'b1;
        @(negedge host_clk);
        // R1 reset state
        chk("R1 tx_free", tx_free, 1);
        chk("R1 overrun_err", overrun_err, 0);
        chk("R1 underrun_err", underrun_err, 0);
        chk("R1 line_dout", line_dout, 1);

        wait_line(20);
        // R7 idle fill after reset does not flag
        chk("R7 idle no underrun", underrun_err, 0);

        // R2 R4: table of bytes written with polling of tx_free
        for (int i = 0; i < NVEC; i++) begin
            wait_free();
            hwrite(VEC[i], 1'b0);
            if (i == 0) chk("R2 free drops after write", tx_free, 0);
        end
        chk("R4 no underrun during paced stream", underrun_err, 0);
        wait_line(100);
        f0 = first_data(0);
        for (int i = 0; i < NVEC; i++)
            // R3 R4 MSB-first, contiguous frames
            chk("R3 R4 frame", (f0 < 0) ? -1 : int'(frame_at(f0 + i)), VEC[i]);
        chk("R7 fill after stream", (f0 < 0) ? -1 : int'(frame_at(f0 + NVEC)), 8'hFF);
        chk("R7 underrun after data", underrun_err, 1);
        chk("R5 free returns", tx_free, 1);
        chk("R6 no overrun when paced", overrun_err, 0);

        // R8 clear
        hclear();
        chk("R8 underrun cleared", underrun_err, 0);
        wait_line(40);
        chk("R7 repeated fill no reflag", underrun_err, 0);

        // R6 write while busy is ignored
        fs = (log_n + 7) / 8;
        hwrite(8'h3C, 1'b0);
        chk("R2 busy after write", tx_free, 0);
        hwrite(8'hC3, 1'b0);
        chk("R6 overrun set", overrun_err, 1);
        wait_line(40);
        f0 = first_data(fs);
        chk("R6 held byte sent", (f0 < 0) ? -1 : int'(frame_at(f0)), 8'h3C);
        chk("R6 ignored byte not sent", (f0 < 0) ? -1 : int'(frame_at(f0 + 1)), 8'hFF);
        chk("R8 overrun sticky", overrun_err, 1);
        chk("R5 free after overrun", tx_free, 1);

        // R8 clear then set-wins-over-clear
        hclear();
        chk("R8 overrun cleared", overrun_err, 0);
        hwrite(8'h5A, 1'b0);
        hwrite(8'h11, 1'b1);
        chk("R8 set beats clear", overrun_err, 1);
        hclear();
        chk("R8 clear after set", overrun_err, 0);
        fs = (log_n + 7) / 8;
        wait_line(40);
        f0 = first_data(fs - 1);
        chk("R6 byte after set/clear", (f0 < 0) ? -1 : int'(frame_at(f0)), 8'h5A);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule